// File: doc/BRIEF.md
# Early-Out Equality Comparator

This block reports whether two operands are equal and takes a number of cycles that depends on the data. On a start pulse it captures both operands. It then looks first at the least-significant nibble of each. If those low bits already differ, the answer "not equal" is ready on the next cycle. If they agree, the block waits for a wide equality check over the full operand width to settle and reports that result after a longer, fixed number of cycles.

A caller drives the operands together with a one-cycle start pulse and waits for the done pulse. The equality flag is valid in the cycle that done is high, and it keeps that value until the next done. The common case in loop counters and similar operands is a mismatch in the low bits, so that case costs one cycle. Operand width, nibble width, the chunk size of the wide check and the slow latency are all parameters, so the same block can also compare address tags.

While a slow comparison is pending, the block takes no new request. A start pulse that arrives in that window is dropped.

Top module: `early_out_cmp`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), done_o and eq_o are both 0.
- R2: When a start is accepted and bits [3:0] of the two operands differ, done_o is high in the cycle right after the start cycle and eq_o is 0 there.
- R3: When a start is accepted, bits [3:0] match and all other bits also match, done_o rises FULL_LAT cycles after the start cycle (default 3) with eq_o equal to 1.
- R4: When a start is accepted, bits [3:0] match but any higher bit differs, done_o rises FULL_LAT cycles after the start cycle with eq_o equal to 0. There is no early answer in this case.
- R5: Each accepted start produces exactly one done cycle. No done appears in the cycles between an accepted slow start and its answer.
- R6: A start that arrives while a slow comparison is pending is ignored. It produces no extra done, and the pending result still reflects the operands captured at the accepted start. Operand changes after an accepted start have no effect on its result.
- R7: eq_o holds its value in every cycle where done_o is low.
- R8: Fast-path starts may be issued on consecutive cycles, and each one gets its own done on the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request pulse; operands are sampled with it |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| done_o | output | 1 | One-cycle completion pulse |
| eq_o | output | 1 | Equality result, valid with done_o and held afterwards |

## Verification
A corrupted wait counter shows up at the ports as a done pulse that comes early, late, twice or never. The bench measures the latency of every request, so any such fault is caught at that request's own done. If the captured operands are wrong, or the wrong path is selected, eq_o is wrong in the done cycle itself. Operands that differ only above the low nibble catch a mux that takes the fast answer by mistake. Faults in how busy state is tracked appear as an extra done, or as a result taken from the wrong operands, within FULL_LAT cycles of an ignored start.

// File: rtl/early_out_cmp_pkg.sv
// Package: shared types for the early-out comparator.
// Assumes: nothing; it carries only type definitions.
package early_out_cmp_pkg;
    // Sequencer state: idle and ready for a request, or waiting on the wide check.
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_WAIT = 1'b1
    } seq_state_t;
endpackage

// File: rtl/eoc_low_check.sv
// Module: eoc_low_check
// Fast path. Flags a mismatch in the lowest LOW_W bits of the two operands.
// Assumes: LOW_W <= WIDTH. The logic is purely combinational and works on live inputs.
module eoc_low_check #(
    parameter int WIDTH = 32,
    parameter int LOW_W = 4
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic             low_miss
);
    // Compare only the low slice; a mismatch there decides the answer.
    always_comb begin
        low_miss = (a[LOW_W-1:0] != b[LOW_W-1:0]);
    end
endmodule

// File: rtl/eoc_wide_eq.sv
// Module: eoc_wide_eq
// Slow path. Full-width equality built from per-chunk compares that are
// AND-reduced. The sequencer gives this logic FULL_LAT-1 cycles to settle.
// Assumes: the operands are held stable while a slow compare is pending.
module eoc_wide_eq #(
    parameter int WIDTH   = 32,
    parameter int CHUNK_W = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic             all_eq
);
    localparam int NCHUNK = (WIDTH + CHUNK_W - 1) / CHUNK_W;
    localparam int PADW   = NCHUNK * CHUNK_W;

    logic [PADW-1:0]   pa;
    logic [PADW-1:0]   pb;
    logic [NCHUNK-1:0] chunk_eq;

    // Zero-extend both operands to a whole number of chunks.
    always_comb begin
        pa = PADW'(a);
        pb = PADW'(b);
    end

    for (genvar i = 0; i < NCHUNK; i++) begin : g_chunk
        // Equality of one chunk.
        always_comb begin
            chunk_eq[i] = (pa[i*CHUNK_W +: CHUNK_W] == pb[i*CHUNK_W +: CHUNK_W]);
        end
    end

    // The operands are equal only if every chunk is equal.
    always_comb begin
        all_eq = &chunk_eq;
    end
endmodule

// File: rtl/eoc_seq.sv
// Module: eoc_seq
// Sequencer. Accepts a start when idle and chooses the fast or the slow answer.
// It times the slow path and drives the done pulse and the held equality flag.
// Assumes: FULL_LAT >= 3, so the one-cycle fast path takes less than half the slow time.
module eoc_seq
    import early_out_cmp_pkg::*;
#(
    parameter int FULL_LAT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic low_miss,
    input  logic wide_eq,
    output logic accept,
    output logic done,
    output logic eq
);
    localparam int CNT_W = $clog2(FULL_LAT);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(FULL_LAT - 1);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    seq_state_t       state_q;
    logic [CNT_W-1:0] cnt_q;

    // A request is taken only when no slow compare is pending.
    always_comb begin
        accept = start && (state_q == SEQ_IDLE);
    end

    // Advance the state, count down the slow wait, and register done and eq.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
            done    <= 1'b0;
            eq      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (state_q == SEQ_WAIT) begin
                if (cnt_q == ONE) begin
                    done    <= 1'b1;
                    eq      <= wide_eq;
                    state_q <= SEQ_IDLE;
                    cnt_q   <= '0;
                end else begin
                    cnt_q <= cnt_q - ONE;
                end
            end else if (accept) begin
                if (low_miss) begin
                    done <= 1'b1;
                    eq   <= 1'b0;
                end else begin
                    state_q <= SEQ_WAIT;
                    cnt_q   <= LOAD;
                end
            end
        end
    end

    // R5: no done while the wait counter is still above one.
    assert_no_early_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_WAIT && cnt_q > ONE) |=> !done);

    // R7: eq only moves together with a done pulse.
    assert_eq_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(eq));

    // R2: a fast-path miss answers "not equal" on the next cycle.
    assert_fast_answer_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && low_miss) |=> (done && !eq));

    // R6: a start during a pending compare does not produce a done next cycle.
    assert_busy_start_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && state_q == SEQ_WAIT && cnt_q > ONE) |=> !done);
endmodule

// File: rtl/early_out_cmp.sv
// Module: early_out_cmp (top)
// Early-out equality comparator. Operands are captured on an accepted start.
// A low-nibble miss answers in one cycle; otherwise the wide compare answers after FULL_LAT cycles.
// Assumes: FULL_LAT >= 3, LOW_W <= WIDTH, and a synchronous active-low reset.
module early_out_cmp #(
    parameter int WIDTH    = 32,
    parameter int LOW_W    = 4,
    parameter int CHUNK_W  = 8,
    parameter int FULL_LAT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic             done_o,
    output logic             eq_o
);
    logic             accept;
    logic             low_miss;
    logic             wide_eq;
    logic [WIDTH-1:0] a_q;
    logic [WIDTH-1:0] b_q;

    // Fast check on the live operands, used in the start cycle.
    eoc_low_check #(.WIDTH(WIDTH), .LOW_W(LOW_W)) u_low (
        .a        (a_i),
        .b        (b_i),
        .low_miss (low_miss)
    );

    // Wide check on the captured operands, sampled when the wait ends.
    eoc_wide_eq #(.WIDTH(WIDTH), .CHUNK_W(CHUNK_W)) u_wide (
        .a      (a_q),
        .b      (b_q),
        .all_eq (wide_eq)
    );

    eoc_seq #(.FULL_LAT(FULL_LAT)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start_i),
        .low_miss (low_miss),
        .wide_eq  (wide_eq),
        .accept   (accept),
        .done     (done_o),
        .eq       (eq_o)
    );

    // Hold the operands of an accepted request for the slow path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
        end else if (accept) begin
            a_q <= a_i;
            b_q <= b_i;
        end
    end

    // R6: captured operands stay put while a start is refused.
    assert_hold_operands_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !accept) |=> ($stable(a_q) && $stable(b_q)));

    // R3/R4: a slow answer matches full equality of the captured operands.
    assert_slow_result_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !$past(accept)) |-> (eq_o == (a_q == b_q)));
endmodule

// File: tb/early_out_cmp_test.sv
module early_out_cmp_test;
    localparam int W   = 32;
    localparam int LAT = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [W-1:0] a_i = '0;
    logic [W-1:0] b_i = '0;
    logic         done_o;
    logic         eq_o;

    int n_chk  = 0;
    int n_fail = 0;

    early_out_cmp #(.WIDTH(W), .FULL_LAT(LAT)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .a_i(a_i), .b_i(b_i), .done_o(done_o), .eq_o(eq_o)
    );

    always #2.5 clk = ~clk;

    function automatic int exp_lat(input logic [W-1:0] a, input logic [W-1:0] b);
        return (a[3:0] != b[3:0]) ? 1 : LAT;
    endfunction

    function automatic logic exp_eq(input logic [W-1:0] a, input logic [W-1:0] b);
        return (a == b);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Issue one request and measure its latency and result.
    task automatic run_one(input logic [W-1:0] a, input logic [W-1:0] b, input string req);
        int lat;
        @(negedge clk);
        a_i = a; b_i = b; start_i = 1'b1;
        lat = 0;
        do begin
            @(negedge clk);
            start_i = 1'b0;
            lat++;
        end while (!done_o && lat < 20);
        check(lat == exp_lat(a, b), {req, " latency"}, lat, exp_lat(a, b));
        check(eq_o == exp_eq(a, b), {req, " eq"}, int'(eq_o), int'(exp_eq(a, b)));
        @(negedge clk);
        check(!done_o, "R5 single done", int'(done_o), 0);
    endtask

    initial begin
        logic [W-1:0] ra, rb;
        logic         held;
        int           extra;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1: reset state.
        check(!done_o && !eq_o, "R1 reset", {30'd0, done_o, eq_o}, 0);
        rst_n = 1'b1;

        // Directed corner cases.
        run_one(32'h0, 32'h0, "R3 zeros equal");
        run_one(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3 ones equal");
        run_one(32'h1234_5678, 32'h1234_5679, "R2 bit0 differs");
        run_one(32'h0000_0008, 32'h0000_0000, "R2 bit3 differs");
        run_one(32'h8000_0005, 32'h0000_0005, "R4 bit31 only");
        run_one(32'h0000_0010, 32'h0000_0000, "R4 bit4 only");

        // R7: eq holds while done is low.
        run_one(32'hA5A5_A5A5, 32'hA5A5_A5A5, "R3 pattern");
        held = eq_o;
        repeat (4) @(negedge clk);
        check(eq_o == held, "R7 eq held", int'(eq_o), int'(held));

        // R6: start while pending is ignored; operand changes do not matter.
        @(negedge clk);
        a_i = 32'h5555_0003; b_i = 32'h5555_0003; start_i = 1'b1;
        @(negedge clk);
        a_i = 32'h0000_0001; b_i = 32'h0000_0002;
        check(!done_o, "R6 no done on ignored start", int'(done_o), 0);
        @(negedge clk);
        start_i = 1'b0;
        check(!done_o, "R6 no early done", int'(done_o), 0);
        @(negedge clk);
        check(done_o && eq_o, "R6 pending result from captured operands",
              {30'd0, done_o, eq_o}, 3);
        extra = 0;
        repeat (4) begin
            @(negedge clk);
            if (done_o) extra++;
        end
        check(extra == 0, "R6 no extra done", extra, 0);

        // R8: back-to-back fast requests.
        @(negedge clk);
        a_i = 32'h1; b_i = 32'h2; start_i = 1'b1;
        @(negedge clk);
        check(done_o && !eq_o, "R8 first fast", {30'd0, done_o, eq_o}, 2);
        a_i = 32'h7; b_i = 32'h3;
        @(negedge clk);
        start_i = 1'b0;
        check(done_o && !eq_o, "R8 second fast", {30'd0, done_o, eq_o}, 2);
        @(negedge clk);
        check(!done_o, "R8 R5 no third done", int'(done_o), 0);

        // Constrained random: a mix of random, equal, and upper-bit-only differences.
        for (int i = 0; i < 300; i++) begin
            ra = $urandom;
            case ($urandom % 3)
                0: rb = $urandom;
                1: rb = ra;
                default: rb = ra ^ ({$urandom} << 4) ^ 32'h10;
            endcase
            run_one(ra, rb, (ra[3:0] != rb[3:0]) ? "R2 random" :
                            (ra == rb) ? "R3 random" : "R4 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule